// File: doc/BRIEF.md
# Return-Stack Program Counter Sequencer

This block drives control flow for a small 8-bit processor. It holds a 14-bit program counter and a private circular stack of eight 14-bit return addresses. The stack is indexed by a 3-bit pointer that software cannot read or write. Each accepted command is one of four kinds: jump, call, return or restart. Jumps, calls and returns may be made conditional on one of four status flags, tested for either polarity.

The program counter holds the address of the opcode of the command being executed. A jump or call is three bytes long: the opcode, then the low address byte, then the high address byte. A return or restart is one byte long. One cycle after a command is accepted, the block raises `done_o` for a single cycle. With it, the block reports the machine-state cost of the command and whether the command was taken. Instruction fetch, the ALU, the memory bus and interrupt acknowledge are not part of this block.

Top module: `flow_seq`

## Requirements
- R1: While `rst_ni` is low, the program counter and the stack pointer are cleared to zero, and `done_o` is 0. The stack entries are not cleared.
- R2: An unconditional jump (`cmd_i`=0, `cond_en_i`=0) loads the program counter with `{hi_i,lo_i}` truncated to its low 14 bits, so bits 7:6 of `hi_i` are dropped.
- R3: A taken call (`cmd_i`=1) writes the return address (program counter + 3) into the slot the pointer names, increments the pointer modulo 8, and loads the target in the same way as R2.
- R4: A taken return (`cmd_i`=2) first decrements the pointer modulo 8 and then loads the program counter from that slot, so returns come back in last-in-first-out order.
- R5: `cond_sel_i` selects the flag to test: 0 selects carry (`flags_i[0]`), 1 selects zero (`flags_i[1]`), 2 selects sign (`flags_i[2]`) and 3 selects parity (`flags_i[3]`). With `cond_en_i`=1, the command acts only when the selected flag equals `cond_pol_i`, so `cond_pol_i`=1 means act-if-true.
- R6: A jump or call reports 11 states when taken. When not taken, it reports 9 states, sets the program counter to its value + 3, and leaves the stack untouched.
- R7: A return reports 5 states when taken. When a conditional return is not taken, it reports 3 states, sets the program counter to its value + 1, and leaves the pointer unchanged.
- R8: A restart (`cmd_i`=3) is always taken. It pushes program counter + 1 as a call would, loads `{rst_vec_i,3'b000}` into the program counter, and reports 5 states.
- R9: The pointer wraps silently. A ninth nested push overwrites the oldest slot, and a pop from pointer 0 reads slot 7.
- R10: `done_o`, `states_o` and `taken_o` are registered and valid exactly one cycle after the cycle in which `cmd_valid_i` was high. When no command is accepted, the program counter holds its value and `done_o` is 0.
- R11: Increments of the program counter wrap modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 2 | 0 jump, 1 call, 2 return, 3 restart |
| cond_en_i | input | 1 | Command is conditional (ignored for restart) |
| cond_sel_i | input | 2 | Flag select: 0 carry, 1 zero, 2 sign, 3 parity |
| cond_pol_i | input | 1 | 1 act when flag set, 0 act when flag clear |
| lo_i | input | 8 | Low target byte |
| hi_i | input | 8 | High target byte |
| rst_vec_i | input | 3 | Restart vector number |
| flags_i | input | 4 | {parity, sign, zero, carry} |
| pc_o | output | 14 | Program counter |
| done_o | output | 1 | One-cycle completion pulse |
| states_o | output | 4 | State cost of the completed command |
| taken_o | output | 1 | Completed command was taken |

## Verification
Two functions can meet in one cycle: a push or pop, and the wrap of the pointer across the 7-to-0 boundary. To provoke this, the bench first fills all eight slots. It then issues nine nested calls, so the ninth call overwrites slot 0 while the pointer rolls back over, and then issues nine returns, so one pop reads slot 7 while the pointer wraps downward. The return addresses are judged against a reference stack of eight entries held in the bench. A mid-run reset, followed by one push and two pops, shows that the pointer restarted at zero while the stack contents survived.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;
  typedef enum logic [1:0] {
    CMD_JMP  = 2'd0,
    CMD_CALL = 2'd1,
    CMD_RET  = 2'd2,
    CMD_RST  = 2'd3
  } flow_cmd_e;

  localparam logic [3:0] ST_BR_TAKEN  = 4'd11;
  localparam logic [3:0] ST_BR_SKIP   = 4'd9;
  localparam logic [3:0] ST_RET_TAKEN = 4'd5;
  localparam logic [3:0] ST_RET_SKIP  = 4'd3;
  localparam logic [3:0] ST_RESTART   = 4'd5;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval (
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       pol_i,
  input  logic [3:0] flags_i,
  output logic       take_o
);
  logic flag_sel;
  assign flag_sel = flags_i[sel_i];
  assign take_o   = !en_i || (flag_sel == pol_i);
endmodule

// File: rtl/flow_ret_stack.sv
module flow_ret_stack #(
  parameter int AW    = 14,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_dec;
  logic [AW-1:0]    mem_q [DEPTH];

  // power-of-two depth: wrap is the natural overflow of the pointer
  assign sp_dec = sp_q - PTR_W'(1);
  assign top_o  = mem_q[sp_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + PTR_W'(1);
    else if (pop_i)  sp_q <= sp_dec;
  end

  // contents deliberately not reset
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[sp_q] <= push_addr_i;
  end
endmodule

// File: rtl/flow_seq.sv
module flow_seq #(
  parameter int AW    = 14,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic          cond_en_i,
  input  logic [1:0]    cond_sel_i,
  input  logic          cond_pol_i,
  input  logic [7:0]    lo_i,
  input  logic [7:0]    hi_i,
  input  logic [2:0]    rst_vec_i,
  input  logic [3:0]    flags_i,
  output logic [AW-1:0] pc_o,
  output logic          done_o,
  output logic [3:0]    states_o,
  output logic          taken_o
);
  import flow_seq_pkg::*;

  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW-1:0] THREE = AW'(3);

  flow_cmd_e     cmd;
  logic          take;
  logic          push, pop;
  logic [AW-1:0] push_addr, top;
  logic [AW-1:0] pc_q, pc_d, pc_p1, pc_p3, target, vector;
  logic [3:0]    states_d, states_q;
  logic          taken_d, taken_q, done_q;

  assign cmd    = flow_cmd_e'(cmd_i);
  assign pc_p1  = pc_q + ONE;
  assign pc_p3  = pc_q + THREE;
  assign target = AW'({hi_i, lo_i});
  assign vector = AW'({rst_vec_i, 3'b000});

  flow_cond_eval u_cond (
    .en_i   (cond_en_i),
    .sel_i  (cond_sel_i),
    .pol_i  (cond_pol_i),
    .flags_i(flags_i),
    .take_o (take)
  );

  flow_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_addr_i(push_addr),
    .top_o      (top)
  );

  always_comb begin
    pc_d      = pc_q;
    push      = 1'b0;
    pop       = 1'b0;
    push_addr = pc_p3;
    states_d  = ST_BR_SKIP;
    taken_d   = take;
    if (cmd_valid_i) begin
      unique case (cmd)
        CMD_JMP: begin
          pc_d     = take ? target : pc_p3;
          states_d = take ? ST_BR_TAKEN : ST_BR_SKIP;
        end
        CMD_CALL: begin
          push     = take;
          pc_d     = take ? target : pc_p3;
          states_d = take ? ST_BR_TAKEN : ST_BR_SKIP;
        end
        CMD_RET: begin
          pop      = take;
          pc_d     = take ? top : pc_p1;
          states_d = take ? ST_RET_TAKEN : ST_RET_SKIP;
        end
        CMD_RST: begin
          push      = 1'b1;
          push_addr = pc_p1;
          pc_d      = vector;
          states_d  = ST_RESTART;
          taken_d   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      done_q   <= 1'b0;
      states_q <= '0;
      taken_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      done_q <= cmd_valid_i;
      if (cmd_valid_i) begin
        states_q <= states_d;
        taken_q  <= taken_d;
      end
    end
  end

  assign pc_o     = pc_q;
  assign done_o   = done_q;
  assign states_o = states_q;
  assign taken_o  = taken_q;
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
  parameter int AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_i,
  input logic          cond_en_i,
  input logic [7:0]    lo_i,
  input logic [7:0]    hi_i,
  input logic [2:0]    rst_vec_i,
  input logic [AW-1:0] pc_o,
  input logic          done_o,
  input logic [3:0]    states_o
);
  AST_DONE_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o); // R10
  AST_NO_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o); // R10
  AST_PC_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(pc_o)); // R10
  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 2'd0 && !cond_en_i) |=>
      (pc_o == AW'({$past(hi_i), $past(lo_i)}))); // R2
  AST_RST_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 2'd3) |=>
      (pc_o == AW'({$past(rst_vec_i), 3'b000}) && states_o == 4'd5)); // R8
  AST_BR_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && states_o == 4'd9) |-> (pc_o == AW'($past(pc_o) + AW'(3)))); // R6
  AST_RET_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && states_o == 4'd3) |-> (pc_o == AW'($past(pc_o) + AW'(1)))); // R7
  AST_STATES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (states_o == 4'd3 || states_o == 4'd5 ||
                states_o == 4'd9 || states_o == 4'd11)); // R6
endmodule

bind flow_seq flow_seq_chk #(.AW(AW)) u_flow_seq_chk (.*);

// File: tb/flow_seq_bench.sv
module flow_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 14;
  localparam int DEPTH      = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [1:0]    cmd_i = '0;
  logic          cond_en_i = 1'b0;
  logic [1:0]    cond_sel_i = '0;
  logic          cond_pol_i = 1'b0;
  logic [7:0]    lo_i = '0, hi_i = '0;
  logic [2:0]    rst_vec_i = '0;
  logic [3:0]    flags_i = '0;
  logic [AW-1:0] pc_o;
  logic          done_o, taken_o;
  logic [3:0]    states_o;

  flow_seq #(.AW(AW), .DEPTH(DEPTH)) u_flow_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .cond_en_i(cond_en_i), .cond_sel_i(cond_sel_i), .cond_pol_i(cond_pol_i),
    .lo_i(lo_i), .hi_i(hi_i), .rst_vec_i(rst_vec_i), .flags_i(flags_i),
    .pc_o(pc_o), .done_o(done_o), .states_o(states_o), .taken_o(taken_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [AW-1:0] m_pc = '0;
  logic [AW-1:0] m_stk [DEPTH];
  int            m_sp = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit cond_ok(input bit en, input logic [1:0] sel, input bit pol,
                                 input logic [3:0] fl);
    return !en || (fl[sel] == pol);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cmd_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check(pc_o == '0, "R1", pc_o, 0);
    check(done_o == 1'b0, "R1", done_o, 0);
    rst_ni = 1'b1;
    m_pc = '0;
    m_sp = 0;
  endtask

  task automatic run_cmd(input logic [1:0] c, input bit en, input logic [1:0] sel,
                         input bit pol, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [2:0] vec, input logic [3:0] fl, input string ovr);
    bit            tk;
    logic [AW-1:0] exp_pc;
    logic [3:0]    exp_st;
    string         tag, stag;
    tk = (c == 2'd3) ? 1'b1 : cond_ok(en, sel, pol, fl);
    case (c)
      2'd0: begin
        exp_pc = tk ? AW'({hi, lo}) : m_pc + AW'(3);
        exp_st = tk ? 4'd11 : 4'd9;
        tag = !tk ? "R6" : (en ? "R5" : "R2");
        stag = "R6";
      end
      2'd1: begin
        exp_pc = tk ? AW'({hi, lo}) : m_pc + AW'(3);
        exp_st = tk ? 4'd11 : 4'd9;
        if (tk) begin
          m_stk[m_sp] = m_pc + AW'(3);
          m_sp = (m_sp + 1) % DEPTH;
        end
        tag = !tk ? "R6" : (en ? "R5" : "R3");
        stag = "R6";
      end
      2'd2: begin
        if (tk) begin
          m_sp = (m_sp + DEPTH - 1) % DEPTH;
          exp_pc = m_stk[m_sp];
        end else exp_pc = m_pc + AW'(1);
        exp_st = tk ? 4'd5 : 4'd3;
        tag = !tk ? "R7" : (en ? "R5" : "R4");
        stag = "R7";
      end
      default: begin
        m_stk[m_sp] = m_pc + AW'(1);
        m_sp = (m_sp + 1) % DEPTH;
        exp_pc = AW'({vec, 3'b000});
        exp_st = 4'd5;
        tag = "R8";
        stag = "R8";
      end
    endcase
    if (ovr != "") tag = ovr;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_i = c; cond_en_i = en; cond_sel_i = sel;
    cond_pol_i = pol; lo_i = lo; hi_i = hi; rst_vec_i = vec; flags_i = fl;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    check(pc_o == exp_pc, tag, pc_o, exp_pc);
    check(states_o == exp_st, stag, states_o, exp_st);
    check(done_o == 1'b1 && taken_o == tk, "R10", {done_o, taken_o}, {1'b1, tk});
    m_pc = exp_pc;
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(done_o == 1'b0, "R10", done_o, 0);
    check(pc_o == m_pc, "R10", pc_o, m_pc);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // fill every slot so later pops are defined
    for (int i = 0; i < DEPTH; i++)
      run_cmd(2'd1, 0, 0, 0, 8'(i * 16), 8'h01, 0, 0, "R3");
    // R2: high bits of hi byte masked
    run_cmd(2'd0, 0, 0, 0, 8'h34, 8'hFF, 0, 0, "R2");
    idle_check();
    // R5: each select and polarity
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++) begin
        run_cmd(2'd0, 1, 2'(s), p[0], 8'h10, 8'h02, 0, 4'(1 << s), "R5");
        run_cmd(2'd0, 1, 2'(s), p[0], 8'h20, 8'h03, 0, 4'hF ^ 4'(1 << s), "R5");
      end
    // R11: increment wraps at 14 bits
    run_cmd(2'd0, 0, 0, 0, 8'hFE, 8'h3F, 0, 0, "R2");
    run_cmd(2'd0, 1, 0, 1, 8'h00, 8'h00, 0, 4'h0, "R11");
    run_cmd(2'd0, 0, 0, 0, 8'hFF, 8'h3F, 0, 0, "R2");
    run_cmd(2'd2, 1, 1, 1, 0, 0, 0, 4'h0, "R11");
    // R9: nine nested calls then nine returns
    for (int i = 0; i < DEPTH + 1; i++)
      run_cmd(2'd1, 0, 0, 0, 8'(8'h40 + i), 8'h05, 0, 0, "R9");
    for (int i = 0; i < DEPTH + 1; i++)
      run_cmd(2'd2, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R8: restart pushes and returns
    run_cmd(2'd3, 0, 0, 0, 0, 0, 3'd7, 0, "R8");
    run_cmd(2'd2, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R1: pointer back at zero after reset, contents kept
    do_reset();
    run_cmd(2'd1, 0, 0, 0, 8'h77, 8'h06, 0, 0, "R1");
    run_cmd(2'd2, 0, 0, 0, 0, 0, 0, 0, "R1");
    run_cmd(2'd2, 0, 0, 0, 0, 0, 0, 0, "R1");
    // random mix
    for (int k = 0; k < 400; k++) begin
      run_cmd(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
              8'($urandom), 8'($urandom), 3'($urandom), 4'($urandom), "");
      if (($urandom % 8) == 0) idle_check();
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule